// File: doc/BRIEF.md
# Bandwidth-Aware Fill Bypass Controller

This block sits beside the fill path of a large direct-mapped DRAM cache and decides, for every line that comes back from main memory, whether the line is written into the cache or dropped. Skipping fills saves cache bandwidth. However, skipping too many fills costs hit rate, so the block measures that cost before it allows skipping.

A small set of sampled cache sets is always filled. A second sampled set is bypassed at random about nine times in ten. The cache reports every lookup and its hit or miss outcome. The block keeps hit and access counts for both sampled groups. At the end of each epoch it compares the two hit rates by cross-multiplication, so no divider is needed. All other sets follow the outcome of that comparison. They bypass at random while the hit-rate gap stays below a programmable margin, and they always fill otherwise.

The four counters are 16 bits each, so the measurement state fits in eight bytes. The random draw comes from a 16-bit shift register that advances once per fill request.

Top module: `bwbyp_ctrl`

## Requirements
- R1: A set index whose low 11 bits are all zero belongs to the always-fill sample group. A set index whose low 11 bits are all one belongs to the bypass sample group. Every other set index is a follower.
- R2: A fill request to an always-fill sample set always yields an insert decision, whatever the follower mode.
- R3: A fill request to a bypass sample set yields a bypass decision when the low 8 bits of the random register are below 230, and an insert decision otherwise. This holds whatever the follower mode.
- R4: A fill request to a follower set follows the rule of R3 while follower bypass mode is on, and always yields insert while the mode is off.
- R5: The decision (`dec_valid` high, `dec_insert` = 1 for insert, 0 for bypass) appears exactly one cycle after the request. `dec_valid` is low in every cycle that does not follow a request.
- R6: The random register resets to 16'hACE1. It shifts left once per fill request, taking in bit15^bit13^bit12^bit10 at bit 0, and holds its value in cycles without a request. Each request uses the value the register holds before that shift.
- R7: Only lookups to sample sets change the counters: the access count of the set's group, and its hit count when `acc_hit` is high. Lookups to follower sets change no counter but still count toward the epoch.
- R8: Every 256th lookup (any set) is an epoch boundary. In that cycle the follower mode is reloaded from the comparison of the current counts. Each counter is then halved before that cycle's own lookup is added. The mode changes at no other time.
- R9: With insert-group hits and accesses Hi and Ai, bypass-group hits and accesses Hb and Ab, and margin `delta_q8`/256, the mode is set to on when (Hi*Ab - Hb*Ai)*256 < delta_q8*Ai*Ab. Otherwise the mode is set to off.
- R10: After reset, `dec_valid` is low, all counters are zero and follower mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A line returned from memory needs a fill decision |
| fill_set | input | 16 | Cache set index of the returned line |
| acc_valid | input | 1 | A cache lookup completed this cycle |
| acc_set | input | 16 | Set index of that lookup |
| acc_hit | input | 1 | The lookup hit |
| delta_q8 | input | 8 | Allowed hit-rate loss, fraction of 256 |
| dec_valid | output | 1 | Decision valid this cycle |
| dec_insert | output | 1 | 1 = insert the line, 0 = skip the fill |

## Verification
The assertions check, on every cycle, the properties that hold locally in time:
- Decision latency and the absence of spurious decisions.
- Forced inserts for always-fill sets and for followers while the mode is off.
- The random register holding still between requests and moving on each one.
- The mode changing only at epoch boundaries.

Other behaviour needs history, so only the bench scenarios can show it:
- Whether the mode switches on or off depends on whole epochs of hit counts, the halving at each boundary and the margin input.
- The exact bypass pattern depends on the random sequence since reset.

The bench drives epochs with small and large hit-rate gaps, and with extreme margins, and predicts each decision from its own model.

// File: rtl/bwbyp_pkg.sv
package bwbyp_pkg;

  localparam int CNT_W   = 16;
  localparam int DELTA_W = 8;
  localparam int RNG_W   = 16;

  typedef enum logic [1:0] {
    SET_FOLLOW   = 2'd0,
    SET_LEAD_INS = 2'd1,
    SET_LEAD_BYP = 2'd2
  } set_class_e;

  function automatic set_class_e classify_set(input logic [31:0] idx, input int unsigned sel_w);
    logic [31:0] mask;
    mask = (32'd1 << sel_w) - 32'd1;
    if ((idx & mask) == 32'd0)  return SET_LEAD_INS;
    if ((idx & mask) == mask)   return SET_LEAD_BYP;
    return SET_FOLLOW;
  endfunction

  function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[RNG_W-2:0], fb};
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] v,
                                                input logic inc, input logic halve);
    logic [CNT_W-1:0] base;
    base = halve ? (v >> 1) : v;
    if (inc && (base != {CNT_W{1'b1}})) return base + 1'b1;
    return base;
  endfunction

  function automatic logic loss_within(input logic [CNT_W-1:0] hi, input logic [CNT_W-1:0] ai,
                                       input logic [CNT_W-1:0] hb, input logic [CNT_W-1:0] ab,
                                       input logic [DELTA_W-1:0] delta);
    logic [2*CNT_W-1:0]            p_ia;
    logic [2*CNT_W-1:0]            p_bi;
    logic [2*CNT_W+DELTA_W-1:0]    p_d;
    logic signed [2*CNT_W+DELTA_W+1:0] lhs;
    logic signed [2*CNT_W+DELTA_W+1:0] rhs;
    p_ia = (2*CNT_W)'(hi) * (2*CNT_W)'(ab);
    p_bi = (2*CNT_W)'(hb) * (2*CNT_W)'(ai);
    p_d  = (2*CNT_W+DELTA_W)'(delta) * (2*CNT_W+DELTA_W)'(ai) * (2*CNT_W+DELTA_W)'(ab);
    lhs  = (signed'({{(DELTA_W+2){1'b0}}, p_ia}) - signed'({{(DELTA_W+2){1'b0}}, p_bi}))
           <<< DELTA_W;
    rhs  = signed'({2'b00, p_d});
    return lhs < rhs;
  endfunction

endpackage

// File: rtl/bwbyp_rng.sv
module bwbyp_rng
  import bwbyp_pkg::*;
#(
  parameter logic [RNG_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [RNG_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= rng_step(state);
  end
endmodule

// File: rtl/bwbyp_stats.sv
module bwbyp_stats
  import bwbyp_pkg::*;
#(
  parameter int EPOCH_ACC = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  set_class_e         acc_cls,
  input  logic               acc_hit,
  input  logic [DELTA_W-1:0] delta,
  output logic               epoch_end,
  output logic               byp_mode
);
  localparam int EP_W = (EPOCH_ACC > 1) ? $clog2(EPOCH_ACC) : 1;
  localparam logic [EP_W-1:0] EP_LAST = EP_W'(EPOCH_ACC - 1);

  logic [CNT_W-1:0] hits_ins, accs_ins, hits_byp, accs_byp;
  logic [EP_W-1:0]  ep_cnt;

  logic inc_acc_ins, inc_hit_ins, inc_acc_byp, inc_hit_byp;
  assign inc_acc_ins = acc_valid && (acc_cls == SET_LEAD_INS);
  assign inc_acc_byp = acc_valid && (acc_cls == SET_LEAD_BYP);
  assign inc_hit_ins = inc_acc_ins && acc_hit;
  assign inc_hit_byp = inc_acc_byp && acc_hit;
  assign epoch_end   = acc_valid && (ep_cnt == EP_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hits_ins <= '0;
      accs_ins <= '0;
      hits_byp <= '0;
      accs_byp <= '0;
      ep_cnt   <= '0;
      byp_mode <= 1'b0;
    end else begin
      hits_ins <= cnt_next(hits_ins, inc_hit_ins, epoch_end);
      accs_ins <= cnt_next(accs_ins, inc_acc_ins, epoch_end);
      hits_byp <= cnt_next(hits_byp, inc_hit_byp, epoch_end);
      accs_byp <= cnt_next(accs_byp, inc_acc_byp, epoch_end);
      if (epoch_end) begin
        ep_cnt   <= '0;
        byp_mode <= loss_within(hits_ins, accs_ins, hits_byp, accs_byp, delta);
      end else if (acc_valid) begin
        ep_cnt <= ep_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bwbyp_decide.sv
module bwbyp_decide
  import bwbyp_pkg::*;
#(
  parameter int RND_W   = 8,
  parameter int BYP_PCT = 90
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  set_class_e       req_cls,
  input  logic             byp_mode,
  input  logic [RNG_W-1:0] rnd,
  output logic             draw_byp,
  output logic             dec_valid,
  output logic             dec_insert
);
  localparam int BYP_THR = (BYP_PCT * (1 << RND_W)) / 100;
  localparam logic [RND_W:0] THR = (RND_W+1)'(BYP_THR);

  logic insert_now;
  assign draw_byp = {1'b0, rnd[RND_W-1:0]} < THR;

  always_comb begin
    case (req_cls)
      SET_LEAD_INS: insert_now = 1'b1;
      SET_LEAD_BYP: insert_now = !draw_byp;
      default:      insert_now = byp_mode ? !draw_byp : 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_insert <= 1'b1;
    end else begin
      dec_valid <= req_valid;
      if (req_valid) dec_insert <= insert_now;
    end
  end
endmodule

// File: rtl/bwbyp_ctrl.sv
module bwbyp_ctrl
  import bwbyp_pkg::*;
#(
  parameter int SET_W     = 16,
  parameter int SEL_W     = 11,
  parameter int EPOCH_ACC = 256,
  parameter int RND_W     = 8,
  parameter int BYP_PCT   = 90
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_valid,
  input  logic [SET_W-1:0]   fill_set,
  input  logic               acc_valid,
  input  logic [SET_W-1:0]   acc_set,
  input  logic               acc_hit,
  input  logic [DELTA_W-1:0] delta_q8,
  output logic               dec_valid,
  output logic               dec_insert
);
  set_class_e       fill_cls, acc_cls;
  logic [RNG_W-1:0] lfsr_q;
  logic             byp_mode, epoch_end, draw_byp;

  assign fill_cls = classify_set(32'(fill_set), SEL_W);
  assign acc_cls  = classify_set(32'(acc_set), SEL_W);

  bwbyp_rng u_rng (
    .clk(clk), .rst_n(rst_n), .step(fill_valid), .state(lfsr_q)
  );

  bwbyp_stats #(.EPOCH_ACC(EPOCH_ACC)) u_stats (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_cls(acc_cls),
    .acc_hit(acc_hit), .delta(delta_q8), .epoch_end(epoch_end), .byp_mode(byp_mode)
  );

  bwbyp_decide #(.RND_W(RND_W), .BYP_PCT(BYP_PCT)) u_dec (
    .clk(clk), .rst_n(rst_n), .req_valid(fill_valid), .req_cls(fill_cls),
    .byp_mode(byp_mode), .rnd(lfsr_q), .draw_byp(draw_byp),
    .dec_valid(dec_valid), .dec_insert(dec_insert)
  );
endmodule

// File: rtl/bwbyp_ctrl_chk.sv
module bwbyp_ctrl_chk
  import bwbyp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fill_valid,
  input set_class_e       fill_cls,
  input logic             byp_mode,
  input logic             epoch_end,
  input logic [RNG_W-1:0] lfsr_q,
  input logic             dec_valid,
  input logic             dec_insert
);
  a_r5_decision_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> dec_valid);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid |=> !dec_valid);
  a_r2_leader_inserts: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_cls == SET_LEAD_INS) |=> dec_insert);
  a_r4_follower_off_inserts: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_cls == SET_FOLLOW && !byp_mode) |=> dec_insert);
  a_r6_rng_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid |=> $stable(lfsr_q));
  a_r6_rng_moves: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !$stable(lfsr_q));
  a_r8_mode_at_epoch_only: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_end |=> $stable(byp_mode));
endmodule

bind bwbyp_ctrl bwbyp_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_cls(fill_cls),
  .byp_mode(byp_mode), .epoch_end(epoch_end), .lfsr_q(lfsr_q),
  .dec_valid(dec_valid), .dec_insert(dec_insert)
);

// File: tb/bwbyp_ctrl_tb_top.sv
module bwbyp_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_valid = 1'b0, acc_valid = 1'b0, acc_hit = 1'b0;
  logic [15:0] fill_set = '0, acc_set = '0;
  logic [7:0] delta_q8 = 8'd16;
  logic dec_valid, dec_insert;

  always #(CLK_P/2) clk = ~clk;

  bwbyp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_set(fill_set),
    .acc_valid(acc_valid), .acc_set(acc_set), .acc_hit(acc_hit),
    .delta_q8(delta_q8), .dec_valid(dec_valid), .dec_insert(dec_insert)
  );

  typedef struct { bit ins; string tag; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_err = 0;

  // independent reference state
  longint m_hi = 0, m_ai = 0, m_hb = 0, m_ab = 0;
  int     m_ep = 0;
  bit     m_mode = 0;
  bit [15:0] m_rng = 16'hACE1;

  function automatic int grp(input bit [15:0] s);
    if (s[10:0] == 11'h000) return 1;
    if (s[10:0] == 11'h7FF) return 2;
    return 0;
  endfunction

  function automatic longint bump(input longint v, input bit inc);
    if (inc && v < 65535) return v + 1;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit fv, input bit [15:0] fs, input bit av,
                     input bit [15:0] as, input bit ah, input string tag);
    exp_t e;
    int ga;
    bit draw, bnd, nm;
    @(negedge clk);
    fill_valid = fv; fill_set = fs; acc_valid = av; acc_set = as; acc_hit = ah;
    if (fv) begin
      draw = (m_rng % 256) < 230;
      case (grp(fs))
        1: e.ins = 1;
        2: e.ins = !draw;
        default: e.ins = m_mode ? !draw : 1'b1;
      endcase
      e.tag = tag;
      sb.push_back(e);
      m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
    end
    ga  = av ? grp(as) : 0;
    bnd = av && (m_ep == 255);
    if (bnd) begin
      nm = ((m_hi * m_ab - m_hb * m_ai) * 256) < (longint'(delta_q8) * m_ai * m_ab);
      m_mode = nm;
      m_hi = m_hi / 2; m_ai = m_ai / 2; m_hb = m_hb / 2; m_ab = m_ab / 2;
      m_ep = 0;
    end else if (av) m_ep++;
    m_ai = bump(m_ai, ga == 1);
    m_hi = bump(m_hi, ga == 1 && ah);
    m_ab = bump(m_ab, ga == 2);
    m_hb = bump(m_hb, ga == 2 && ah);
  endtask

  task automatic idle();
    cyc(0, 16'h0, 0, 16'h0, 0, "");
  endtask

  // monitor: compares each produced decision with the queued prediction
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (dec_valid) begin
        if (sb.size() == 0) check(0, "R5 spurious decision", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(dec_insert == e.ins, e.tag, int'(dec_insert), int'(e.ins));
        end
      end else if (sb.size() != 0) begin
        check(0, "R5 missing decision", 0, 1);
        void'(sb.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  // one epoch of 256 lookups with fills interleaved (fill skipped every third cycle)
  task automatic run_epoch(input int n_i, input int h_i, input int n_b, input int h_b,
                           input string tag);
    int k = 0;
    for (int i = 0; i < n_i; i++) begin
      cyc(k % 3 != 0, (k % 2) ? 16'h2345 : 16'hFFFF, 1, 16'h1800, i < h_i, "R6 draw sequence");
      k++;
    end
    for (int i = 0; i < n_b; i++) begin
      cyc(k % 3 != 0, (k % 2) ? 16'h07FF : 16'h0800, 1, 16'h37FF, i < h_b, tag);
      k++;
    end
    for (int i = n_i + n_b; i < 256; i++) begin
      cyc(k % 3 != 0, 16'h4321, 1, 16'h5555, 1'b1, "R7 follower lookups");
      k++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dec_valid == 1'b0, "R10 dec_valid in reset", int'(dec_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    idle();
    check(dec_valid == 1'b0, "R10 dec_valid after reset", int'(dec_valid), 0);
    // R10: mode off after reset, followers insert
    for (int i = 0; i < 8; i++) cyc(1, 16'h1234 + 16'(i), 0, 0, 0, "R10 follower after reset");
    // R2 always-fill sample sets
    cyc(1, 16'h0000, 0, 0, 0, "R2 insert leader");
    cyc(1, 16'h0800, 0, 0, 0, "R2 insert leader");
    cyc(1, 16'hF800, 0, 0, 0, "R2 insert leader");
    // R3 bypass sample sets, many draws
    for (int i = 0; i < 40; i++) cyc(1, (i % 2) ? 16'hFFFF : 16'h07FF, 0, 0, 0, "R3 bypass leader");
    // R1 near-miss indices are followers
    cyc(1, 16'h0801, 0, 0, 0, "R1 near-leader follower");
    cyc(1, 16'h0FFE, 0, 0, 0, "R1 near-leader follower");
    // R6 idle gaps keep the draw sequence
    idle(); idle();
    for (int i = 0; i < 6; i++) cyc(1, 16'h07FF, 0, 0, 0, "R6 hold then draw");
    // epoch 1: small gap, margin 16/256 -> mode on
    delta_q8 = 8'd16;
    run_epoch(100, 50, 100, 48, "R9 small gap epoch");
    for (int i = 0; i < 40; i++) cyc(1, 16'h2000 + 16'(i), 0, 0, 0, "R9 followers bypass");
    // epoch 2: large gap -> mode off
    run_epoch(128, 128, 128, 0, "R8 large gap epoch");
    for (int i = 0; i < 20; i++) cyc(1, 16'h3000 + 16'(i), 0, 0, 0, "R8 followers insert");
    // R2/R3 sample sets ignore mode
    cyc(1, 16'h1000, 0, 0, 0, "R2 leader mode off");
    // epoch 3: full margin -> mode on
    delta_q8 = 8'd255;
    run_epoch(120, 40, 120, 10, "R9 wide margin epoch");
    for (int i = 0; i < 30; i++) cyc(1, 16'h4000 + 16'(i), 0, 0, 0, "R9 wide margin followers");
    cyc(1, 16'h2800, 0, 0, 0, "R2 leader mode on");
    // epoch 4: zero margin, equal rates -> mode off
    delta_q8 = 8'd0;
    run_epoch(100, 50, 100, 50, "R9 zero margin epoch");
    for (int i = 0; i < 20; i++) cyc(1, 16'h5000 + 16'(i), 0, 0, 0, "R9 zero margin followers");
    idle(); idle(); idle();
    finish_run();
  end
endmodule